// File: doc/BRIEF.md
# Slow-Idle Clock Divider Controller

This block slows a processor core down while it sits in idle waiting for an interrupt. An idle command comes with a flag that says whether a divisor is given, and a 2-bit code that selects the divisor. Without a divisor, the idle is plain: every enable keeps running at full rate and a pending unmasked interrupt ends the idle on the next clock. With a divisor, the block produces one clock-enable pulse every n cycles. That pulse drives the core and the three derived clock domains (serial clock, clock output and timer), so the core keeps working at the reduced rate. No clock is gated anywhere.

Interrupts are looked at only on enabled edges. When an unmasked one is found, the block leaves idle and pulses `wake` for one cycle, and the core continues with the instruction after the idle. Cycle-steal transfers stay possible throughout. `dma_req`/`dma_gnt` form a valid/ready pair: the requester holds `dma_req` high until it sees `dma_gnt`, and the grant comes only in a cycle whose edge is enabled. Back-pressure therefore lasts at most n cycles in divided idle and is zero otherwise.

Top module: `idle_clkdiv_ctrl`

## Requirements
- R1: After reset the block is running (`in_idle`=0, `wake`=0), and all four enables and `dma_gnt` follow full rate.
- R2: An idle command with `idle_div_en`=0 enters plain idle. All enables stay at 1 every cycle, and an unmasked pending interrupt makes `wake` 1 in the very next cycle.
- R3: An idle command with `idle_div_en`=1 uses the divisor n = 16, 32, 64 or 128 for codes 0, 1, 2, 3. `core_ce` is then 1 in exactly one cycle of every n, and the first such cycle is the n-th cycle after entry.
- R4: In every cycle, `sclk_ce`, `clkout_ce` and `timer_ce` equal `core_ce`.
- R5: In divided idle, interrupts are sampled only in cycles with `core_ce`=1. `wake` rises in the cycle after such a sample, so it comes between 1 and n cycles after an unmasked interrupt appears.
- R6: An interrupt counts as unmasked only when its `irq_mask` bit is 1. Pending interrupts whose mask bit is 0 never end idle.
- R7: `dma_grant` is 1 exactly when `dma_req` is 1 in a cycle whose edge is enabled (`core_ce`=1). This holds in running, plain idle and divided idle.
- R8: Idle commands are taken only while running. A command given during idle leaves the divisor and the state unchanged.
- R9: `wake` lasts one cycle. From that cycle on, the block is running at full rate again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_req | input | 1 | Idle command strobe |
| idle_div_en | input | 1 | 1 when the command carries a divisor |
| idle_div_code | input | 2 | Divisor code: 0→16, 1→32, 2→64, 3→128 |
| irq_pend | input | 6 | Pending interrupt lines |
| irq_mask | input | 6 | 1 enables the matching interrupt |
| dma_req | input | 1 | Cycle-steal request, held until granted |
| core_ce | output | 1 | Core clock enable |
| sclk_ce | output | 1 | Serial clock enable |
| clkout_ce | output | 1 | Clock-output enable |
| timer_ce | output | 1 | Timer clock enable |
| in_idle | output | 1 | Block is in plain or divided idle |
| wake | output | 1 | One-cycle pulse when idle ends |
| dma_gnt | output | 1 | Cycle-steal grant |

## Verification
The enables and `dma_gnt` depend combinationally on the current state and inputs, so they are due in the same cycle as the stimulus. A command or interrupt seen at an edge changes `in_idle` and `wake` one cycle later. In divided idle, the first enable comes n cycles after entry. The bench drives inputs just after a rising edge and compares every output with a behavioural model at the falling edge. It then advances the model after the next rising edge, so each result is checked in exactly the cycle it is due. Interrupt-to-wake latency is also measured against the 1..n bound for each code and several arrival offsets.

// File: rtl/idle_div_pkg.sv
package idle_div_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_PLAIN = 2'd1,
    ST_SLOW  = 2'd2
  } idle_st_e;
endpackage

// File: rtl/idle_div_counter.sv
module idle_div_counter #(
  parameter int BASE_LOG2 = 4,
  parameter int SEL_W     = 2,
  parameter int CNT_W     = BASE_LOG2 + (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  always_comb begin
    lim  = (CNT_W'(1) << (BASE_LOG2 + int'(sel))) - CNT_W'(1);
    tick = active && (cnt == lim);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (!active) cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + CNT_W'(1);
  end

  // R3
  tick_spaced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/idle_wake_fsm.sv
module idle_wake_fsm
  import idle_div_pkg::*;
#(
  parameter int NIRQ  = 6,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_req,
  input  logic             idle_div_en,
  input  logic [SEL_W-1:0] idle_div_code,
  input  logic [NIRQ-1:0]  irq_pend,
  input  logic [NIRQ-1:0]  irq_mask,
  input  logic             tick,
  output idle_st_e         state,
  output logic [SEL_W-1:0] sel,
  output logic             wake
);
  idle_st_e state_nx;
  logic     unmasked;
  logic     leave;

  always_comb begin
    unmasked = |(irq_pend & irq_mask);
    leave    = 1'b0;
    state_nx = state;
    unique case (state)
      ST_RUN:   if (idle_req) state_nx = idle_div_en ? ST_SLOW : ST_PLAIN;
      ST_PLAIN: leave = unmasked;
      ST_SLOW:  leave = unmasked && tick;
      default:  state_nx = ST_RUN;
    endcase
    if (leave) state_nx = ST_RUN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_RUN;
      sel   <= '0;
      wake  <= 1'b0;
    end else begin
      state <= state_nx;
      wake  <= leave;
      if (state == ST_RUN && idle_req) sel <= idle_div_code;
    end
  end

  // R9
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);
  // R8
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RUN) |=> $stable(sel) || (state == ST_RUN));
  // R6
  masked_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PLAIN && !(|(irq_pend & irq_mask))) |=> (state == ST_PLAIN));
endmodule

// File: rtl/idle_clkdiv_ctrl.sv
module idle_clkdiv_ctrl
  import idle_div_pkg::*;
#(
  parameter int NIRQ      = 6,
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_req,
  input  logic             idle_div_en,
  input  logic [SEL_W-1:0] idle_div_code,
  input  logic [NIRQ-1:0]  irq_pend,
  input  logic [NIRQ-1:0]  irq_mask,
  input  logic             dma_req,
  output logic             core_ce,
  output logic             sclk_ce,
  output logic             clkout_ce,
  output logic             timer_ce,
  output logic             in_idle,
  output logic             wake,
  output logic             dma_gnt
);
  localparam int CNT_W = BASE_LOG2 + (1 << SEL_W) - 1;

  idle_st_e         state;
  logic [SEL_W-1:0] sel;
  logic             tick;
  logic             slow;

  assign slow = (state == ST_SLOW);

  idle_div_counter #(.BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .active(slow), .sel(sel), .tick(tick));

  idle_wake_fsm #(.NIRQ(NIRQ), .SEL_W(SEL_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .idle_div_en(idle_div_en),
    .idle_div_code(idle_div_code), .irq_pend(irq_pend), .irq_mask(irq_mask),
    .tick(tick), .state(state), .sel(sel), .wake(wake));

  always_comb begin
    core_ce   = slow ? tick : 1'b1;
    sclk_ce   = core_ce;
    clkout_ce = core_ce;
    timer_ce  = core_ce;
    in_idle   = (state != ST_RUN);
    dma_gnt   = dma_req && core_ce;
  end

  // R1
  run_full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_idle |-> core_ce);
  // R5
  wake_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(in_idle) && !in_idle);
endmodule

// File: tb/idle_clkdiv_ctrl_bench.sv
module idle_clkdiv_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       idle_req = 1'b0, idle_div_en = 1'b0;
  logic [1:0] idle_div_code = 2'd0;
  logic [5:0] irq_pend = '0, irq_mask = '0;
  logic       dma_req = 1'b0;
  logic core_ce, sclk_ce, clkout_ce, timer_ce, in_idle, wake, dma_gnt;

  int checks = 0, errors = 0, cyc = 0;
  int ms = 0, mn = 16, mcnt = 0;
  bit mwake = 0;

  always #10 clk = ~clk;

  idle_clkdiv_ctrl u_idle_clkdiv_ctrl (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .idle_div_en(idle_div_en),
    .idle_div_code(idle_div_code), .irq_pend(irq_pend), .irq_mask(irq_mask),
    .dma_req(dma_req), .core_ce(core_ce), .sclk_ce(sclk_ce), .clkout_ce(clkout_ce),
    .timer_ce(timer_ce), .in_idle(in_idle), .wake(wake), .dma_gnt(dma_gnt));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // one cycle: compare at falling edge, advance the model after the rising edge
  task automatic step();
    bit ece, unm;
    @(negedge clk);
    ece = (ms == 2) ? (mcnt == mn - 1) : 1'b1;
    unm = |(irq_pend & irq_mask);
    chk(core_ce == ece, ms == 2 ? "R3 core_ce" : "R2 core_ce", core_ce, ece);
    chk(sclk_ce == core_ce && clkout_ce == core_ce && timer_ce == core_ce,
        "R4 derived", {sclk_ce, clkout_ce, timer_ce}, {3{core_ce}});
    chk(in_idle == (ms != 0), "R8 in_idle", in_idle, ms != 0);
    chk(wake == mwake, "R9 wake", wake, mwake);
    chk(dma_gnt == (dma_req && ece), "R7 dma_gnt", dma_gnt, dma_req && ece);
    @(posedge clk);
    #1;
    cyc++;
    case (ms)
      0: begin
        mwake = 0;
        if (idle_req) begin
          ms = idle_div_en ? 2 : 1;
          mn = 16 << idle_div_code;
          mcnt = 0;
        end
      end
      1: begin mwake = unm; if (unm) ms = 0; end
      default: begin
        mwake = ece && unm;
        mcnt = ece ? 0 : mcnt + 1;
        if (ece && unm) ms = 0;
      end
    endcase
  endtask

  task automatic enter(input bit den, input int code);
    idle_req = 1; idle_div_en = den; idle_div_code = 2'(code);
    step();
    idle_req = 0;
  endtask

  // raise an unmasked interrupt and measure cycles until wake (R5)
  task automatic irq_wake(input int n, input string tag);
    int lat = 0;
    irq_mask = 6'b000100; irq_pend = 6'b000100;
    while (!wake && lat < 400) begin step(); lat++; end
    chk(lat >= 1 && lat <= n, tag, lat, n);
    irq_pend = '0;
    step();
  endtask

  initial begin
    int wd = 0;
    while (wd < 200000) begin @(posedge clk); wd++; end
    errors++;
    $display("FAIL watchdog actual=%0d expected=<%0d", wd, 200000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    chk(!in_idle && !wake && core_ce, "R1 reset", {in_idle, wake, core_ce}, 3'b001);
    repeat (3) step();
    // R7: grant at full rate
    dma_req = 1; step(); dma_req = 0; step();
    // R2, R6: plain idle, masked interrupt ignored, unmasked ends idle next cycle
    enter(0, 0);
    irq_pend = 6'b010000; irq_mask = 6'b001111;
    repeat (6) step();
    chk(in_idle, "R6 masked ignored", in_idle, 1);
    dma_req = 1; step(); dma_req = 0;
    irq_wake(1, "R2 plain latency");
    repeat (2) step();
    // R3, R5: every divisor, various arrival offsets
    for (int c = 0; c < 4; c++) begin
      enter(1, c);
      repeat (7 * c + 3) step();
      irq_wake(16 << c, "R5 latency");
      repeat (2) step();
    end
    // R8: second command during divided idle ignored; R7: held request granted
    enter(1, 0);
    repeat (4) step();
    idle_req = 1; idle_div_en = 1; idle_div_code = 2'd3; step(); idle_req = 0;
    dma_req = 1;
    begin
      int w = 0;
      while (!dma_gnt && w < 200) begin step(); w++; end
      chk(w >= 1 && w <= 16, "R7 grant wait", w, 16);
    end
    dma_req = 0;
    // R6: masked interrupt over two divided periods
    irq_pend = 6'b100000; irq_mask = 6'b011111;
    repeat (40) step();
    chk(in_idle, "R6 masked slow", in_idle, 1);
    irq_pend = '0;
    irq_wake(16, "R5 latency after R8");
    // R5: interrupt already pending at entry wakes at first enabled edge
    irq_mask = 6'b000001; irq_pend = 6'b000001;
    enter(1, 1);
    repeat (31) step();
    chk(!wake && in_idle, "R5 early", wake, 0);
    step();
    chk(wake && !in_idle, "R9 wake at n", wake, 1);
    irq_pend = '0;
    repeat (3) step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule